// File: doc/BRIEF.md
# SPI Slave Peripheral with Register Interface

This block is the target side of a four-wire serial link. A local processor sees four byte-wide registers through a simple read/write strobe bus. Those registers are a control word, an interrupt mask, an event/status word and a data port. Bytes written to the data port queue up in a small transmit FIFO and are sent to the external master on MISO. Bytes the master sends on MOSI land in a receive FIFO, and the processor drains them by reading the same data port.

The serial pins are sampled in the system clock domain through two-flop synchronizers. Clock edges are found on the synchronized copies, so the system clock must run at least four times faster than the serial clock. The control word selects:

- enable,
- clock polarity,
- clock phase,
- bit order.

An interrupt line goes high whenever any status bit is set and its mask bit is clear.

A byte placed in the transmit FIFO before the master starts clocking is the first byte returned to the master. A chip-select deassertion in the middle of a byte throws that byte away and restarts bit counting.

Top module: `spi_slave_regif`

## Requirements
- R1: After reset the control register reads 0x00, the mask register reads 0x3F, the status register reads 0x08 (transmit FIFO empty only), irq is low and spi_miso_oe is low.
- R2: While control bit 0 (enable) is 0, activity on the serial clock and chip select receives no byte, sets no status bit, and keeps spi_miso_oe and spi_miso low.
- R3: Control bit 2 is polarity and bit 1 is phase. The leading edge is rising for polarity 0 and falling for polarity 1. With phase 0, MOSI is sampled on the leading edge and MISO changes on the trailing edge. With phase 1 the two roles swap. All four combinations transfer bytes correctly.
- R4: Control bit 3 = 0 sends and receives MSB first, and bit 3 = 1 sends and receives LSB first, on both MISO and MOSI.
- R5: Writing address 3 pushes into a 2-entry transmit FIFO, and a write while it is full is dropped. Queued bytes leave on MISO in write order, and a byte queued before chip select falls is the first byte the master reads.
- R6: Completed received bytes are read back in arrival order from address 3, and each read removes one byte. Reading address 3 while the receive FIFO is empty returns 0x00.
- R7: Status bit 1 sets when chip select falls while enabled. It clears on a read of the status register (address 2).
- R8: Status bit 0 is 1 exactly while the receive FIFO holds a byte. Reading the status register does not clear it.
- R9: Status bit 2 is 1 while the receive FIFO is full, and status bit 3 is 1 while the transmit FIFO is empty.
- R10: If a byte starts with the transmit FIFO empty, 0x00 is shifted out and status bit 4 sets. Bit 4 clears on a status read.
- R11: A byte completed while the receive FIFO is full is dropped, the stored bytes are kept, and status bit 5 sets. Bit 5 clears on a status read.
- R12: irq is 1 exactly when some status bit is 1 and the same bit of the mask register (address 1, bits 5:0, 1 = masked) is 0.
- R13: A rising chip select in the middle of a byte discards the partial byte, never pushes it to the receive FIFO, and restarts bit counting for the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops or clears at the clock edge) |
| bus_addr | input | 2 | Register address: 0 control, 1 mask, 2 status, 3 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request, level |
| spi_sck | input | 1 | Serial clock from the master |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when not driven |
| spi_miso_oe | output | 1 | Output enable for spi_miso |

## Verification
The bench goes after the edge roles of each mode. A design that samples on the shift edge returns every received byte shifted by one bit, and the same byte comes back wrong on MISO.

It queues two bytes and then three, and drains them, to reach both FIFO limits. A FIFO that accepts a third entry overwrites its oldest byte or returns it twice.

It ends a transaction after three bits. A design that keeps counting pushes a garbage byte, or misaligns the byte that follows.

It reads the status register twice in a row to tell the one-shot flags from the level flags. A design that clears the receive-ready bit on read loses it there.

// File: rtl/spi_slave_regif.sv
module spi_slave_regif #(
  parameter int FIFO_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       spi_sck,
  input  logic       spi_csn,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(FIFO_DEPTH);
  localparam logic [1:0] A_CTRL = 2'd0, A_MASK = 2'd1, A_STAT = 2'd2, A_DATA = 2'd3;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [3:0] ctrl;
  logic [5:0] mask;
  wire en   = ctrl[0];
  wire cpha = ctrl[1];
  wire cpol = ctrl[2];
  wire lsb  = ctrl[3];

  // pin synchronizers and edge history
  logic [1:0] sck_q, cs_q, mosi_q;
  logic       sck_p, cs_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= 2'b11;
      mosi_q <= '0;
      sck_p  <= 1'b0;
      cs_p   <= 1'b1;
    end else begin
      sck_q  <= {sck_q[0], spi_sck};
      cs_q   <= {cs_q[0], spi_csn};
      mosi_q <= {mosi_q[0], spi_mosi};
      sck_p  <= sck_q[1];
      cs_p   <= cs_q[1];
    end

  wire sck_s  = sck_q[1];
  wire cs_s   = cs_q[1];
  wire mosi_s = mosi_q[1];
  wire active = en & ~cs_s;
  wire rise   = sck_s & ~sck_p;
  wire fall   = ~sck_s & sck_p;
  wire lead   = cpol ? fall : rise;
  wire trail  = cpol ? rise : fall;
  wire smp    = active & (cpha ? trail : lead);
  wire shf    = active & (cpha ? lead : trail);
  wire cs_fell = en & cs_p & ~cs_s;

  // bus decode
  wire wr_ctrl = bus_wr & (bus_addr == A_CTRL);
  wire wr_mask = bus_wr & (bus_addr == A_MASK);
  wire wr_data = bus_wr & (bus_addr == A_DATA);
  wire rd_stat = bus_rd & (bus_addr == A_STAT);
  wire rd_data = bus_rd & (bus_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      mask <= '1;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata[3:0];
      if (wr_mask) mask <= bus_wdata[5:0];
    end

  // transmit FIFO
  logic [7:0]    tx_mem [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          load_evt;
  wire tx_empty = (tx_cnt == '0);
  wire tx_push  = wr_data & (tx_cnt != FULL_CNT);
  wire tx_pop   = load_evt & ~tx_empty;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= inc(tx_wp);
      if (tx_pop)  tx_rp <= inc(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  // shift engine
  logic [7:0] tx_sr, rx_sr;
  logic [2:0] bit_cnt;
  logic       sr_full, sr_zero;
  wire [7:0] rx_next   = lsb ? {mosi_s, rx_sr[7:1]} : {rx_sr[6:0], mosi_s};
  wire       byte_done = smp & (bit_cnt == 3'd7);
  wire       und_evt   = smp & (bit_cnt == 3'd0) & sr_zero;
  assign load_evt = ~sr_full & ((cs_fell & ~cpha) | (shf & (bit_cnt == 3'd0)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      bit_cnt <= '0;
      sr_full <= 1'b0;
      sr_zero <= 1'b0;
    end else if (!active) begin
      bit_cnt <= '0;
    end else begin
      if (load_evt) begin
        tx_sr   <= tx_empty ? 8'h00 : tx_mem[tx_rp];
        sr_full <= ~tx_empty;
        sr_zero <= tx_empty;
      end else if (shf) begin
        tx_sr <= lsb ? (tx_sr >> 1) : (tx_sr << 1);
      end
      if (smp) begin
        rx_sr   <= rx_next;
        bit_cnt <= bit_cnt + 3'd1;
        sr_full <= 1'b0;
        sr_zero <= 1'b0;
      end
    end

  assign spi_miso_oe = active;
  assign spi_miso    = active & (lsb ? tx_sr[0] : tx_sr[7]);

  // receive FIFO
  logic [7:0]    rx_mem [FIFO_DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  wire rx_full = (rx_cnt == FULL_CNT);
  wire rx_push = byte_done & ~rx_full;
  wire ovf_evt = byte_done & rx_full;
  wire rx_pop  = rd_data & (rx_cnt != '0);

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= rx_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= inc(rx_wp);
      if (rx_pop)  rx_rp <= inc(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  // status and interrupt
  logic st_csf, st_und, st_ovf;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_csf <= 1'b0;
      st_und <= 1'b0;
      st_ovf <= 1'b0;
    end else begin
      st_csf <= cs_fell | (st_csf & ~rd_stat);
      st_und <= und_evt | (st_und & ~rd_stat);
      st_ovf <= ovf_evt | (st_ovf & ~rd_stat);
    end

  wire [5:0] status = {st_ovf, st_und, tx_empty, rx_full, st_csf, rx_cnt != '0};
  assign irq = |(status & ~mask);

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = {4'h0, ctrl};
      A_MASK:  bus_rdata = {2'b00, mask};
      A_STAT:  bus_rdata = {2'b00, status};
      default: bus_rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : 8'h00;
    endcase

  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!spi_miso_oe && !spi_miso));

  a_r5_fifo_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= FULL_CNT) && (rx_cnt <= FULL_CNT));

  a_r7_csf_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !cs_fell) |=> !st_csf);

  a_r8_ready_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && rx_cnt != '0) |=> (rx_cnt != '0));

  a_r11_overflow_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && rx_full && !rx_pop) |=> (rx_full && st_ovf));

  a_r12_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 6'h3F) |-> !irq);

  a_r13_abort_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |=> (bit_cnt == 3'd0));
endmodule

// File: tb/test_spi_slave_regif.sv
module test_spi_slave_regif;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;

  int n_chk = 0, n_fail = 0;
  logic cpha_b = 1'b0, lsb_b = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  spi_slave_regif i_spi_slave_regif (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] c);
    wr(2'd0, {4'h0, c});
    cpha_b = c[1]; lsb_b = c[3];
    @(negedge clk);
    sck = c[2];
    repeat (2*H) @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk);
    csn = 1'b0;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic cs_high();
    csn = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] mo, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      int b;
      b = lsb_b ? i : 7 - i;
      if (!cpha_b) begin
        mosi = mo[b];
        repeat (H) @(negedge clk);
        got[b] = miso;
        sck = ~sck;
        repeat (H) @(negedge clk);
        sck = ~sck;
      end else begin
        sck = ~sck;
        mosi = mo[b];
        repeat (H) @(negedge clk);
        got[b] = miso;
        sck = ~sck;
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
  endtask

  // driver: queues the expected MISO byte, then clocks the byte out
  task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_mi, input string tag);
    logic [7:0] g;
    exp_q.push_back(exp_mi);
    tag_q.push_back(tag);
    shift_bits(mo, 8, g);
    got_q.push_back(g);
  endtask

  // monitor: compares captured MISO bytes against the scoreboard
  always @(negedge clk)
    if (got_q.size() != 0 && exp_q.size() != 0)
      check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    logic [7:0] dummy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd_chk(2'd0, 8'h00, "R1 ctrl reset");
    rd_chk(2'd1, 8'h3F, "R1 mask reset");
    rd_chk(2'd2, 8'h08, "R1 status reset");
    check("R1 irq reset", {7'b0, irq}, 8'h00);
    check("R1 oe reset", {7'b0, miso_oe}, 8'h00);

    // R2 disabled: clocks ignored
    cs_low();
    check("R2 oe while disabled", {7'b0, miso_oe}, 8'h00);
    xfer(8'hC9, 8'h00, "R2 miso while disabled");
    cs_high();
    rd_chk(2'd2, 8'h08, "R2 status untouched");
    rd_chk(2'd3, 8'h00, "R2 no byte received");

    // R5 preload, R3 mode 0 MSB first, R9 flags
    set_mode(4'h1);
    wr(2'd3, 8'hA5);
    wr(2'd3, 8'h3C);
    rd_chk(2'd2, 8'h00, "R9 tx not empty");
    cs_low();
    xfer(8'h12, 8'hA5, "R5 preloaded first byte");
    xfer(8'h34, 8'h3C, "R5 second byte order");
    cs_high();
    rd_chk(2'd2, 8'h0F, "R9 R7 status after two bytes");
    rd_chk(2'd2, 8'h0D, "R8 R7 ready kept, csf cleared");
    rd_chk(2'd3, 8'h12, "R6 first rx byte");
    rd_chk(2'd3, 8'h34, "R6 second rx byte");
    rd_chk(2'd3, 8'h00, "R6 empty read");
    rd_chk(2'd2, 8'h08, "R8 ready drops when empty");

    // R3 R4 mode 1 LSB first
    set_mode(4'hB);
    wr(2'd3, 8'h81);
    cs_low();
    xfer(8'h5A, 8'h81, "R3 R4 mode1 lsb miso");
    cs_high();
    rd_chk(2'd3, 8'h5A, "R3 R4 mode1 lsb mosi");
    rd_chk(2'd2, 8'h0A, "R7 mode1 status");

    // R3 mode 2 MSB first
    set_mode(4'h5);
    wr(2'd3, 8'hE7);
    cs_low();
    xfer(8'h3C, 8'hE7, "R3 mode2 miso");
    cs_high();
    rd_chk(2'd3, 8'h3C, "R3 mode2 mosi");
    rd_chk(2'd2, 8'h0A, "R7 mode2 status");

    // R3 R4 mode 3 LSB first
    set_mode(4'hF);
    wr(2'd3, 8'h4D);
    cs_low();
    xfer(8'hB2, 8'h4D, "R3 R4 mode3 miso");
    cs_high();
    rd_chk(2'd3, 8'hB2, "R3 R4 mode3 mosi");
    rd_chk(2'd2, 8'h0A, "R7 mode3 status");

    // R10 underrun
    set_mode(4'h1);
    cs_low();
    xfer(8'h66, 8'h00, "R10 underrun shifts zero");
    cs_high();
    rd_chk(2'd2, 8'h1B, "R10 underrun flag");
    rd_chk(2'd2, 8'h09, "R10 underrun cleared on read");
    rd_chk(2'd3, 8'h66, "R6 byte during underrun");

    // R11 overflow, R12 interrupt masking
    cs_low();
    xfer(8'h11, 8'h00, "R10 zero byte 1");
    xfer(8'h22, 8'h00, "R10 zero byte 2");
    xfer(8'h33, 8'h00, "R10 zero byte 3");
    cs_high();
    check("R12 all masked no irq", {7'b0, irq}, 8'h00);
    rd_chk(2'd2, 8'h3F, "R11 overflow flag");
    rd_chk(2'd2, 8'h0D, "R11 sticky flags cleared");
    wr(2'd1, 8'h3E);
    @(negedge clk);
    check("R12 ready unmasked irq", {7'b0, irq}, 8'h01);
    rd_chk(2'd3, 8'h11, "R11 oldest kept");
    rd_chk(2'd3, 8'h22, "R11 second kept");
    @(negedge clk);
    check("R12 irq drops with ready", {7'b0, irq}, 8'h00);
    rd_chk(2'd3, 8'h00, "R11 newest dropped");
    wr(2'd1, 8'h37);
    @(negedge clk);
    check("R12 tx empty unmasked irq", {7'b0, irq}, 8'h01);
    wr(2'd1, 8'h3F);
    @(negedge clk);
    check("R12 remasked", {7'b0, irq}, 8'h00);

    // R13 abort partial byte
    wr(2'd3, 8'h96);
    cs_low();
    shift_bits(8'hFF, 3, dummy);
    cs_high();
    rd_chk(2'd2, 8'h0A, "R13 no partial push");
    wr(2'd3, 8'hC3);
    cs_low();
    xfer(8'h7E, 8'hC3, "R13 aligned after abort miso");
    cs_high();
    rd_chk(2'd3, 8'h7E, "R13 aligned after abort mosi");
    rd_chk(2'd3, 8'h00, "R13 only one byte stored");
    rd_chk(2'd2, 8'h0A, "R13 status after abort");

    // R5 write to full TX FIFO dropped
    wr(2'd3, 8'h01);
    wr(2'd3, 8'h02);
    wr(2'd3, 8'h03);
    cs_low();
    xfer(8'hA1, 8'h01, "R5 full fifo first");
    xfer(8'hA2, 8'h02, "R5 full fifo second");
    xfer(8'hA3, 8'h00, "R5 third write dropped");
    cs_high();
    rd_chk(2'd3, 8'hA1, "R6 order a");
    rd_chk(2'd3, 8'hA2, "R6 order b");
    rd_chk(2'd2, 8'h3A, "R10 R11 flags after burst");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule